// File: doc/BRIEF.md
# Pipelined SPI Converter Responder

This block is the device side of a 16-bit SPI link that behaves like a multi-channel sampling converter. A controller shifts in one command word per chip-select window. Each complete word can select a channel and an input-range setting, and at the end of that word the block captures the selected channel's value from a parallel sample bus. That capture comes back to the controller on MISO two frames later. It arrives as a 16-bit word with the channel number in the top nibble and the value left-justified below it.

The responder gives a sequencer or SPI controller a synthesizable partner for closed-loop tests. The controller's handling of the two-frame latency, the channel tags and the range setting can then be exercised without an analog model. The SPI pins are oversampled by the system clock through a synchronizer, so the block runs entirely in one clock domain. The SPI clock must therefore be a good deal slower than the system clock.

Top module: `adc_spi_responder`

## Requirements
- R1: A command word carries a manual-select flag in bit 12, a write-enable flag in bit 11, a channel number in bits 10:7 and a doubled-range flag in bit 6. The channel and range are latched only from a complete frame in which bits 12 and 11 are both 1. A complete frame with either flag at 0 leaves both settings unchanged.
- R2: The output `range_double` shows the doubled-range flag from the most recent accepted command.
- R3: The channel sampled at the end of frame N is returned on MISO during frame N+2.
- R4: Each returned word has the channel number in bits 15:12 and the sample left-justified in bits 11:(12-RES_BITS). Any bits below that are 0.
- R5: After reset, the first two complete frames return 16'h0000, and `range_double` is 0.
- R6: A frame is complete only if exactly 16 SCLK rising edges occur while CS_n is low. A frame ended by CS_n rising after fewer or more edges changes no setting and does not advance the result pipeline.
- R7: MOSI is sampled on SCLK rising edges and MISO is updated after SCLK falling edges, most significant bit first. MISO is 0 while CS_n is high.
- R8: A channel number at or above NUM_CH returns its tag with a data field of 0.
- R9: A complete frame that is not an accepted command samples the previously latched channel, using the bus value present at the end of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock from the controller, idle low |
| cs_n | input | 1 | Active-low chip select; its rising edge ends a frame |
| mosi | input | 1 | Command bits from the controller |
| samples | input | NUM_CH*RES_BITS | Per-channel sample values, channel c at bits [c*RES_BITS +: RES_BITS] |
| miso | output | 1 | Result bits to the controller |
| range_double | output | 1 | Latched doubled-range setting |

## Verification
The bench builds the responder with NUM_CH = 12 and RES_BITS = 10. Channels 12 to 15 are therefore valid tags with no input behind them, which brings the zero-data case within reach. The two zero bits below a 10-bit sample are also observable in every returned word. The sample bus is changed between frames while a channel stays latched, so the checks can tell a fresh capture from a stale one. Frames cut short at 9 edges and run long at 17 edges test that the pipeline stays put.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

    localparam int FRAME_BITS = 16;
    localparam int TAG_BITS   = 4;
    localparam int FIELD_BITS = 12;
    localparam int MAX_CH     = 1 << TAG_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic                manual;
        logic                wr_en;
        logic [TAG_BITS-1:0] chan;
        logic                dbl_range;
    } cmd_t;

    typedef struct packed {
        logic [TAG_BITS-1:0] chan;
        logic                dbl_range;
    } settings_t;

    typedef struct packed {
        logic [TAG_BITS-1:0]   tag;
        logic [FIELD_BITS-1:0] data;
    } word_t;

    // Field positions are fixed by the command format the controller sends.
    function automatic cmd_t decode_cmd(input logic [FRAME_BITS-1:0] w);
        cmd_t c;
        c.manual    = w[12];
        c.wr_en     = w[11];
        c.chan      = w[10:7];
        c.dbl_range = w[6];
        return c;
    endfunction

    function automatic logic cmd_accepted(input cmd_t c);
        return c.manual & c.wr_en;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_active,
    output logic mosi_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   sclk_q;
    logic [SYNC_STAGES:0]   cs_q;
    logic [SYNC_STAGES-1:0] mosi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
            cs_q   <= {cs_q[SYNC_STAGES-1:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
        end
    end

    // MOSI passes through the same depth as SCLK, so the data bit lines up with the detected edge.
    assign sclk_rise = sclk_q[LAST] & ~sclk_q[SYNC_STAGES];
    assign sclk_fall = ~sclk_q[LAST] & sclk_q[SYNC_STAGES];
    assign cs_fall   = ~cs_q[LAST] & cs_q[SYNC_STAGES];
    assign cs_rise   = cs_q[LAST] & ~cs_q[SYNC_STAGES];
    assign cs_active = ~cs_q[LAST];
    assign mosi_s    = mosi_q[LAST];

endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import adc_resp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_rise,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  cs_active,
    input  logic                  mosi_s,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] cmd_word
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_BITS + 1);

    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
        end else if (cs_active && sclk_rise) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], mosi_s};
            if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Short frames and overlong frames both miss this count, so they are dropped.
    assign frame_done = cs_rise && (cnt_q == FULL);
    assign cmd_word   = shift_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= OVER); // R6
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> cnt_q == '0); // R6

endmodule

// File: rtl/result_pipe.sv
module result_pipe
    import adc_resp_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int RES_BITS = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_done,
    input  logic [FRAME_BITS-1:0]      cmd_word,
    input  logic [NUM_CH*RES_BITS-1:0] samples,
    output word_t                      out_word,
    output logic                       range_double
);
    localparam int PAD = FIELD_BITS - RES_BITS;

    cmd_t      cmd;
    logic      take;
    settings_t set_q;
    logic [TAG_BITS-1:0] pick_ch;
    logic [RES_BITS-1:0] chan_val [MAX_CH];
    word_t     fresh, conv_q, out_q;

    assign cmd     = decode_cmd(cmd_word);
    assign take    = frame_done && cmd_accepted(cmd);
    assign pick_ch = take ? cmd.chan : set_q.chan;

    // Tags without a channel behind them read as zero.
    for (genvar g = 0; g < MAX_CH; g++) begin : g_chan
        if (g < NUM_CH) begin : g_live
            assign chan_val[g] = samples[g*RES_BITS +: RES_BITS];
        end else begin : g_none
            assign chan_val[g] = '0;
        end
    end

    always_comb begin
        fresh.tag  = pick_ch;
        fresh.data = FIELD_BITS'(chan_val[pick_ch]) << PAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q  <= '0;
            conv_q <= '0;
            out_q  <= '0;
        end else if (frame_done) begin
            conv_q <= fresh;
            out_q  <= conv_q;
            if (take) set_q <= '{chan: cmd.chan, dbl_range: cmd.dbl_range};
        end
    end

    assign out_word     = out_q;
    assign range_double = set_q.dbl_range;

    AST_PIPE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> out_q == $past(conv_q)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(conv_q) && $stable(out_q) && $stable(set_q)); // R6
    AST_CMD_GATED: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !(cmd.manual && cmd.wr_en)) |=> $stable(set_q)); // R1
    AST_TAG_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> conv_q.tag == set_q.chan); // R4

    if (PAD > 0) begin : g_pad_chk
        AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
            conv_q.data[PAD-1:0] == '0); // R4
    end

endmodule

// File: rtl/adc_spi_responder.sv
module adc_spi_responder
    import adc_resp_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int RES_BITS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       mosi,
    input  logic [NUM_CH*RES_BITS-1:0] samples,
    output logic                       miso,
    output logic                       range_double
);
    logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active, mosi_s;
    logic frame_done;
    logic [FRAME_BITS-1:0] cmd_word;
    word_t out_word;
    logic [FRAME_BITS-1:0] tx_q;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .cs_active(cs_active), .mosi_s(mosi_s)
    );

    frame_rx u_rx (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .cs_active(cs_active), .mosi_s(mosi_s),
        .frame_done(frame_done), .cmd_word(cmd_word)
    );

    result_pipe #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_pipe (
        .clk(clk), .rst(rst), .frame_done(frame_done), .cmd_word(cmd_word),
        .samples(samples), .out_word(out_word), .range_double(range_double)
    );

    // The word for this frame is loaded when select falls and shifts out MSB first on falling SCLK.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (cs_fall) begin
            tx_q <= out_word;
        end else if (cs_active && sclk_fall) begin
            tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign miso = cs_active ? tx_q[FRAME_BITS-1] : 1'b0;

    AST_MISO_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !cs_fall) |=> $stable(tx_q)); // R7
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cs_active |-> !miso); // R7

endmodule

// File: tb/tb_adc_spi_responder.sv
module tb_adc_spi_responder;
    localparam int NCH  = 12;
    localparam int RES  = 10;
    localparam int HALF = 6;
    localparam int GAP  = 10;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, range_double;
    logic [NCH*RES-1:0] samples = '0;

    always #10 clk = ~clk;

    adc_spi_responder #(.NUM_CH(NCH), .RES_BITS(RES)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .samples(samples), .miso(miso), .range_double(range_double)
    );

    int n_checks = 0, n_fail = 0;
    int base = 0;
    logic [15:0] m_conv = '0, m_out = '0;
    logic [3:0]  m_ch = '0;
    logic        m_rng = 1'b0;

    function automatic logic [RES-1:0] smp(int ch, int b);
        return RES'((ch * 53 + b) % 1024);
    endfunction

    function automatic logic [15:0] expect_word(logic [3:0] ch, int b);
        logic [11:0] d;
        d = (ch < NCH) ? (12'(smp(int'(ch), b)) << (12 - RES)) : 12'h000;
        return {ch, d};
    endfunction

    function automatic logic [15:0] mk(bit man, bit wr, logic [3:0] ch, bit rng);
        return {3'b000, man, wr, ch, rng, 6'b000000};
    endfunction

    task automatic set_samples(int b);
        base = b;
        for (int c = 0; c < NCH; c++) samples[c*RES +: RES] = smp(c, b);
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(logic [15:0] cmd, int nbits, output logic [15:0] rx);
        rx = '0;
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? cmd[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 16) rx[15-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
        if (nbits == 16) begin
            if (cmd[12] && cmd[11]) begin
                m_ch  = cmd[10:7];
                m_rng = cmd[6];
            end
            m_out  = m_conv;
            m_conv = expect_word(m_ch, base);
        end
    endtask

    task automatic frame(string req, logic [15:0] cmd);
        logic [15:0] exp, rx;
        exp = m_out;
        xfer(cmd, 16, rx);
        check(req, rx, exp);
    endtask

    task automatic t_reset;
        check("R5", {15'd0, range_double}, 16'd0);
        check("R7", {15'd0, miso}, 16'd0);
        frame("R5", mk(1, 1, 4'd3, 1'b0));
        frame("R5", mk(1, 1, 4'd5, 1'b0));
        frame("R3", mk(1, 1, 4'd7, 1'b1));
        check("R2", {15'd0, range_double}, 16'd1);
        frame("R3", mk(1, 1, 4'd0, 1'b1));
    endtask

    task automatic t_hold;
        set_samples(311);
        frame("R9", 16'h0000);
        set_samples(622);
        frame("R9", 16'h0000);
        frame("R9", 16'h0000);
        frame("R9", 16'h0000);
    endtask

    task automatic t_ignore;
        frame("R1", mk(1, 1, 4'd6, 1'b1));
        frame("R1", mk(0, 1, 4'd2, 1'b0));
        check("R1", {15'd0, range_double}, 16'd1);
        frame("R1", mk(1, 0, 4'd2, 1'b0));
        check("R1", {15'd0, range_double}, 16'd1);
        frame("R1", 16'h0000);
        frame("R1", 16'h0000);
    endtask

    task automatic t_range;
        frame("R2", mk(1, 1, 4'd1, 1'b0));
        check("R2", {15'd0, range_double}, 16'd0);
        frame("R2", mk(1, 1, 4'd1, 1'b1));
        check("R2", {15'd0, range_double}, 16'd1);
    endtask

    task automatic t_abort;
        logic [15:0] rx;
        xfer(mk(1, 1, 4'd9, 1'b0), 9, rx);
        check("R6", {15'd0, range_double}, 16'd1);
        frame("R6", 16'h0000);
        xfer(mk(1, 1, 4'd10, 1'b0), 17, rx);
        check("R6", {15'd0, range_double}, 16'd1);
        frame("R6", 16'h0000);
        frame("R6", 16'h0000);
    endtask

    task automatic t_out_of_range;
        frame("R8", mk(1, 1, 4'd14, 1'b0));
        frame("R8", mk(1, 1, 4'd11, 1'b0));
        frame("R8", mk(1, 1, 4'd15, 1'b0));
        frame("R8", 16'h0000);
        frame("R8", 16'h0000);
    endtask

    task automatic t_sweep;
        set_samples(1000);
        for (int c = 0; c < NCH; c++) frame("R4", mk(1, 1, 4'(c), 1'b0));
        set_samples(77);
        for (int c = NCH - 1; c >= 0; c--) frame("R4", mk(1, 1, 4'(c), 1'b0));
        frame("R4", 16'h0000);
        frame("R4", 16'h0000);
        check("R7", {15'd0, miso}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        set_samples(5);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_hold();
        t_ignore();
        t_range();
        t_abort();
        t_out_of_range();
        t_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule